// File: doc/BRIEF.md
# Companion and Main Core Cluster Switch Controller

This controller decides which processor cores of a two-cluster arrangement receive power and run. One side is a single low-leakage companion core that handles light work; the other side is a group of up to `NMAIN` fast main cores. A frequency governor outside the block presents a requested frequency (in MHz) and a workload figure once per sample. From these the controller picks the active cluster and the number of enabled main cores. It drives one power-gate enable per core and one run enable per cluster, and produces the single frequency shared by every running core.

A request above the companion cap moves work to the main cluster. A request at or below the cap minus a programmable margin moves it back, so an idle request of 0 always ends on the companion core. Each handover powers the incoming side and waits a programmable settle time, during which the outgoing side keeps running. It then spends one quiet cycle with nothing running, starts the incoming side and gates the outgoing one. While the main cluster is active, the core count moves one step at a time, and only after the workload stays past a threshold for a programmable number of consecutive samples.

Top module: `core_cluster_ctrl`

## Requirements
- R1: After reset only the companion rail is powered, the companion runs, `freq_out` is `FMIN`, `mode` is 0 and `active_cores` is 0.
- R2: In companion mode each accepted sample sets `freq_out` to the request clamped into [`FMIN`, `CAP`].
- R3: In companion mode a sample requesting more than `CAP` starts a switch. The switch ends in main mode with one core and `freq_out` equal to the request clamped into [`FMIN`, `FMAX`].
- R4: A switch powers the incoming side first and holds for max(min(`settle`,`SETTLE_MAX`),1) cycles while the outgoing side still runs. Next comes one cycle with neither side running, then the incoming side runs and the outgoing rail is gated. `mode` reads 2 for settle+1 cycles. The default `SETTLE_MAX` is 2 ms of a 125 MHz clock.
- R5: `comp_run` and `main_run` are never both 1, and at least one rail is always powered.
- R6: In main mode a sample with request + `hyst` <= `CAP` switches back to the companion. The companion then runs at that request clamped, so a zero (idle) request returns to the companion. A request above that bound keeps the main cluster.
- R7: In main mode, a sample with `load` >= `up_thr` while fewer than `NMAIN` cores are on counts as an up sample. `persist` consecutive up samples add exactly one core, and a `persist` of 0 acts as 1.
- R8: In main mode, a sample that is not an up sample and has `load` <= `dn_thr` while more than one core is on counts as a down sample. `persist` consecutive down samples remove one core. Any other sample clears both counts, and the count stays within 1..`NMAIN`.
- R9: In main mode `freq_out` is the request clamped into [`FMIN`, `FMAX`] and applies to all running main cores. `main_pwr_en` has exactly the lowest `active_cores` bits set.
- R10: Samples presented while `mode` is 2 are ignored: `freq_out` does not change and the switch result is unchanged.
- R11: `mode` encodes 0 for companion, 1 for main and 2 for switching. `active_cores` gives the number of powered main cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_valid | input | 1 | One governor sample this cycle |
| req_freq | input | FREQ_W | Requested frequency, MHz |
| load | input | LOAD_W | Workload figure for this sample |
| up_thr | input | LOAD_W | Workload at or above which a core is added |
| dn_thr | input | LOAD_W | Workload at or below which a core is removed |
| persist | input | CNT_W | Consecutive samples needed per core step |
| hyst | input | FREQ_W | Margin below `CAP` for returning to the companion |
| settle | input | SET_W | Rail settle wait, cycles |
| comp_pwr_en | output | 1 | Companion rail enable |
| main_pwr_en | output | NMAIN | Main core rail enables |
| comp_run | output | 1 | Companion run enable |
| main_run | output | 1 | Main cluster run enable |
| freq_out | output | FREQ_W | Shared frequency, MHz |
| mode | output | 2 | 0 companion, 1 main, 2 switching |
| active_cores | output | CORE_W | Powered main cores |

## Verification
The assertions take for granted that `hyst` does not exceed `CAP`, that `FMIN` <= `CAP` <= `FMAX`, and that the configuration inputs stay steady while a switch is in flight. The stimulus changes thresholds, margin, persistence and settle time only between samples, and only while no switch is under way. Random samples keep `dn_thr` below `up_thr` and cluster requests around the cap, so both switch directions and the hysteresis band come up often.

// File: rtl/core_cluster_ctrl.sv
module core_cluster_ctrl #(
  parameter int FREQ_W     = 12,
  parameter int LOAD_W     = 8,
  parameter int CNT_W      = 4,
  parameter int SET_W      = 18,
  parameter int NMAIN      = 4,
  parameter int CAP        = 500,
  parameter int FMIN       = 50,
  parameter int FMAX       = 1500,
  parameter int SETTLE_MAX = 250000,
  localparam int CORE_W    = $clog2(NMAIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [FREQ_W-1:0] req_freq,
  input  logic [LOAD_W-1:0] load,
  input  logic [LOAD_W-1:0] up_thr,
  input  logic [LOAD_W-1:0] dn_thr,
  input  logic [CNT_W-1:0]  persist,
  input  logic [FREQ_W-1:0] hyst,
  input  logic [SET_W-1:0]  settle,
  output logic              comp_pwr_en,
  output logic [NMAIN-1:0]  main_pwr_en,
  output logic              comp_run,
  output logic              main_run,
  output logic [FREQ_W-1:0] freq_out,
  output logic [1:0]        mode,
  output logic [CORE_W-1:0] active_cores
);

  localparam logic [FREQ_W-1:0] CAP_V  = FREQ_W'(CAP);
  localparam logic [FREQ_W-1:0] FMIN_V = FREQ_W'(FMIN);
  localparam logic [FREQ_W-1:0] FMAX_V = FREQ_W'(FMAX);
  localparam logic [SET_W-1:0]  SMAX_V = SET_W'(SETTLE_MAX);
  localparam logic [CORE_W-1:0] NMAX_V = CORE_W'(NMAIN);

  typedef enum logic [1:0] {S_COMP, S_SETTLE, S_XFER, S_MAIN} st_t;

  st_t               st;
  logic              to_main;
  logic [CORE_W-1:0] ncores;
  logic [CNT_W-1:0]  up_cnt, dn_cnt;
  logic [SET_W-1:0]  settle_cnt;
  logic [FREQ_W-1:0] tgt_freq, freq_q;

  function automatic logic [FREQ_W-1:0] clip(input logic [FREQ_W-1:0] f,
                                             input logic [FREQ_W-1:0] hi);
    if (f < FMIN_V) return FMIN_V;
    if (f > hi) return hi;
    return f;
  endfunction

  logic [SET_W-1:0] settle_eff;
  logic [CNT_W:0]   pe;
  logic             go_up, go_dn, up_hit, dn_hit, up_fire, dn_fire;

  assign settle_eff = (settle > SMAX_V) ? SMAX_V : settle;
  assign pe         = (persist == '0) ? (CNT_W+1)'(1) : {1'b0, persist};
  assign go_up      = req_freq > CAP_V;
  assign go_dn      = ({1'b0, req_freq} + {1'b0, hyst}) <= {1'b0, CAP_V};
  assign up_hit     = (load >= up_thr) && (ncores < NMAX_V);
  assign dn_hit     = !up_hit && (load <= dn_thr) && (ncores > CORE_W'(1));
  assign up_fire    = ({1'b0, up_cnt} + (CNT_W+1)'(1)) >= pe;
  assign dn_fire    = ({1'b0, dn_cnt} + (CNT_W+1)'(1)) >= pe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_COMP;
      to_main    <= 1'b0;
      ncores     <= '0;
      up_cnt     <= '0;
      dn_cnt     <= '0;
      settle_cnt <= '0;
      tgt_freq   <= FMIN_V;
      freq_q     <= FMIN_V;
    end else begin
      case (st)
        S_COMP: if (sample_valid) begin
          if (go_up) begin
            st         <= S_SETTLE;
            to_main    <= 1'b1;
            ncores     <= CORE_W'(1);
            settle_cnt <= settle_eff;
            tgt_freq   <= clip(req_freq, FMAX_V);
          end else begin
            freq_q <= clip(req_freq, CAP_V);
          end
        end
        S_SETTLE: begin
          if (settle_cnt <= SET_W'(1)) st <= S_XFER;
          else settle_cnt <= settle_cnt - SET_W'(1);
        end
        S_XFER: begin
          st     <= to_main ? S_MAIN : S_COMP;
          freq_q <= tgt_freq;
          up_cnt <= '0;
          dn_cnt <= '0;
          if (!to_main) ncores <= '0;
        end
        S_MAIN: if (sample_valid) begin
          if (go_dn) begin
            st         <= S_SETTLE;
            to_main    <= 1'b0;
            settle_cnt <= settle_eff;
            tgt_freq   <= clip(req_freq, CAP_V);
          end else begin
            freq_q <= clip(req_freq, FMAX_V);
            if (up_hit) begin
              dn_cnt <= '0;
              if (up_fire) begin
                ncores <= ncores + CORE_W'(1);
                up_cnt <= '0;
              end else begin
                up_cnt <= up_cnt + CNT_W'(1);
              end
            end else if (dn_hit) begin
              up_cnt <= '0;
              if (dn_fire) begin
                ncores <= ncores - CORE_W'(1);
                dn_cnt <= '0;
              end else begin
                dn_cnt <= dn_cnt + CNT_W'(1);
              end
            end else begin
              up_cnt <= '0;
              dn_cnt <= '0;
            end
          end
        end
        default: st <= S_COMP;
      endcase
    end
  end

  for (genvar i = 0; i < NMAIN; i++) begin : g_gate
    assign main_pwr_en[i] = ncores > CORE_W'(i);
  end

  assign comp_pwr_en  = st != S_MAIN;
  assign comp_run     = (st == S_COMP) || (st == S_SETTLE && to_main);
  assign main_run     = (st == S_MAIN) || (st == S_SETTLE && !to_main);
  assign freq_out     = freq_q;
  assign mode         = (st == S_COMP) ? 2'd0 : (st == S_MAIN) ? 2'd1 : 2'd2;
  assign active_cores = ncores;

endmodule

// File: rtl/cluster_ctrl_chk.sv
module cluster_ctrl_chk #(
  parameter int FREQ_W = 12,
  parameter int NMAIN  = 4,
  parameter int CORE_W = 3,
  parameter int CAP    = 500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              comp_pwr_en,
  input logic [NMAIN-1:0]  main_pwr_en,
  input logic              comp_run,
  input logic              main_run,
  input logic [FREQ_W-1:0] freq_out,
  input logic [1:0]        mode,
  input logic [CORE_W-1:0] active_cores
);

  // R5
  run_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(comp_run && main_run));

  // R5
  some_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comp_pwr_en || (main_pwr_en != '0));

  // R2
  comp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comp_run |-> (int'(freq_out) <= CAP));

  // R4
  gate_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(comp_pwr_en) |-> main_run);

  // R4
  quiet_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(main_run) && $past(mode) == 2'd2) |-> $past(!comp_run));

  // R9
  main_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (active_cores >= CORE_W'(1) && int'(active_cores) <= NMAIN
                        && $countones(main_pwr_en) == int'(active_cores)));

  // R8
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && $past(mode) == 2'd1) |->
      (int'(active_cores) <= int'($past(active_cores)) + 1 &&
       int'($past(active_cores)) <= int'(active_cores) + 1));

  // R10
  hold_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && $past(mode) == 2'd2) |-> $stable(freq_out));

  // R11
  mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

endmodule

bind core_cluster_ctrl cluster_ctrl_chk #(
  .FREQ_W(FREQ_W), .NMAIN(NMAIN), .CORE_W($clog2(NMAIN + 1)), .CAP(CAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .comp_pwr_en(comp_pwr_en), .main_pwr_en(main_pwr_en),
  .comp_run(comp_run), .main_run(main_run), .freq_out(freq_out), .mode(mode),
  .active_cores(active_cores)
);

// File: tb/test_core_cluster_ctrl.sv
module test_core_cluster_ctrl;
  localparam int FW = 12, LW = 8, CW = 4, SW = 18, NM = 4;
  localparam int CAP = 500, FMIN = 50, FMAX = 1500, SMAX = 40;

  logic clk = 0, rst_n = 0;
  logic sample_valid = 0;
  logic [FW-1:0] req_freq = 0, hyst = 0, freq_out;
  logic [LW-1:0] load = 0, up_thr = 200, dn_thr = 50;
  logic [CW-1:0] persist = 1;
  logic [SW-1:0] settle = 3;
  logic comp_pwr_en, comp_run, main_run;
  logic [NM-1:0] main_pwr_en;
  logic [1:0] mode;
  logic [2:0] active_cores;

  core_cluster_ctrl #(.FREQ_W(FW), .LOAD_W(LW), .CNT_W(CW), .SET_W(SW), .NMAIN(NM),
    .CAP(CAP), .FMIN(FMIN), .FMAX(FMAX), .SETTLE_MAX(SMAX)) i_core_cluster_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .req_freq(req_freq),
    .load(load), .up_thr(up_thr), .dn_thr(dn_thr), .persist(persist), .hyst(hyst),
    .settle(settle), .comp_pwr_en(comp_pwr_en), .main_pwr_en(main_pwr_en),
    .comp_run(comp_run), .main_run(main_run), .freq_out(freq_out), .mode(mode),
    .active_cores(active_cores));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit m_main = 0;
  int m_n = 0, m_up = 0, m_dn = 0, m_freq = FMIN;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clip(int f, int hi);
    if (f < FMIN) return FMIN;
    if (f > hi) return hi;
    return f;
  endfunction

  task automatic verify(string tag);
    chk({tag, " R11 mode"}, mode, m_main ? 1 : 0);
    chk({tag, " R11 cores"}, active_cores, m_n);
    chk({tag, " R9 freq"}, freq_out, m_freq);
    chk({tag, " R9 mask"}, main_pwr_en, (1 << m_n) - 1);
    chk({tag, " R5 comp pwr"}, comp_pwr_en, m_main ? 0 : 1);
    chk({tag, " R5 runs"}, {comp_run, main_run}, m_main ? 1 : 2);
  endtask

  task automatic send(int req, int ld, bit inject);
    bit sw;
    int n;
    sw = 0;
    if (!m_main) begin
      if (req > CAP) begin sw = 1; m_main = 1; m_n = 1; m_freq = clip(req, FMAX); end
      else m_freq = clip(req, CAP);
    end else if (req + int'(hyst) <= CAP) begin
      sw = 1; m_main = 0; m_freq = clip(req, CAP);
    end else begin
      int pe;
      pe = (persist == 0) ? 1 : int'(persist);
      m_freq = clip(req, FMAX);
      if (ld >= int'(up_thr) && m_n < NM) begin
        m_dn = 0;
        if (m_up + 1 >= pe) begin m_n++; m_up = 0; end else m_up++;
      end else if (ld <= int'(dn_thr) && m_n > 1) begin
        m_up = 0;
        if (m_dn + 1 >= pe) begin m_n--; m_dn = 0; end else m_dn++;
      end else begin m_up = 0; m_dn = 0; end
    end
    @(negedge clk);
    sample_valid = 1; req_freq = FW'(req); load = LW'(ld);
    @(negedge clk);
    sample_valid = 0;
    if (sw) begin
      n = (int'(settle) > SMAX) ? SMAX : int'(settle);
      if (n < 1) n = 1;
      chk("R4 switching", mode, 2);
      chk("R4 both rails up", {comp_pwr_en, main_pwr_en != 0}, 3);
      chk("R4 outgoing still runs", {comp_run, main_run}, m_main ? 2 : 1);
      if (inject) begin
        sample_valid = 1; req_freq = FW'($urandom_range(0, 1600)); load = LW'($urandom);
      end
      repeat (n) @(negedge clk);
      chk("R4 quiet cycle", {comp_run, main_run, mode}, 2);
      @(negedge clk);
      sample_valid = 0;
      m_up = 0; m_dn = 0;
      if (!m_main) m_n = 0;
      verify(inject ? "R10 after switch" : "R3 R6 after switch");
    end else begin
      verify(m_main ? "R7 R8 main" : "R2 comp");
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    verify("R1 reset");
    rst_n = 1;
    @(negedge clk);
    verify("R1 after release");
    send(300, 0, 0);
    send(10, 0, 0);
    send(500, 0, 0);
    hyst = 50; settle = 5;
    send(501, 0, 0);
    send(480, 100, 0);
    send(451, 100, 0);
    send(450, 100, 0);
    settle = 100;
    send(2000, 100, 1);
    persist = 3;
    send(900, 250, 0);
    send(900, 250, 0);
    send(900, 100, 0);
    for (int k = 0; k < 3; k++) send(900, 250, 0);
    persist = 0;
    for (int k = 0; k < 5; k++) send(900, 255, 0);
    for (int k = 0; k < 5; k++) send(900, 0, 0);
    settle = 0;
    send(0, 0, 1);
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 9) == 0) begin
        up_thr  = LW'($urandom_range(120, 255));
        dn_thr  = LW'($urandom_range(0, 110));
        hyst    = FW'($urandom_range(0, 120));
        persist = CW'($urandom_range(0, 4));
        settle  = SW'($urandom_range(0, 12));
      end
      send($urandom_range(0, 3) == 0 ? $urandom_range(0, 1600) : $urandom_range(380, 620),
           $urandom_range(0, 255), $urandom_range(0, 1) == 1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule